// File: doc/BRIEF.md
# Auxiliary I/O and System-Control Register Block

This block is the small register island of a workstation I/O companion chip. A CPU reaches it through a simple single-cycle register bus. It holds a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary control bytes, a 16-bit LED word and a 32-bit system-control word. It also has one write-only power-management location. Side effects are tied to some writes. A latched power-fail status drives an interrupt, and a write bit clears it. Command bits fire one-clock request pulses toward the floppy controller, the power supply, the reset logic and the CPU, and these bits are not kept.

Two reset inputs are provided. The system reset clears the working control registers, but the diagnostic byte, the system-control word and the LED word keep their contents. Only the power-on reset clears all state. The main register group is decoded at fixed offsets from a main base. Each auxiliary byte and the power-management location has its own base, and each base is a parameter.

Top module: `auxio_sysctl_regs`

## Requirements
- R1: Offsets from MAIN_BASE decode as follows: configuration at +0x1800000, diagnostic at +0x1A00000, modem control at +0x1B00000, LED word (16 bits) at +0x1600000 and system control (32 bits) at +0x1F00000. Aux1, aux2 and power management each sit at their own base. Any other address reads as zero, and writes to it change nothing.
- R2: Read data appears on rd_data in the cycle after the read strobe. rd_data is zero in any cycle that does not follow a read.
- R3: pf_irq is high exactly when aux2 bit 5 (power-fail status) and configuration bit 3 (power-interrupt enable) are both set. It follows every configuration write, aux2 write and power-fail input change.
- R4: When pwr_fail changes, aux2 bit 5 becomes pwr_fail AND configuration bit 3. If an aux2 write lands in the same cycle, the input change decides bit 5.
- R5: An aux2 write keeps only bits 0 (power off) and 1 (status clear) of the data and carries bit 5 over. If bit 1 is written as 1, bit 5 is cleared and bit 1 is not stored, so only bit 0 remains.
- R6: An aux2 write that leaves bit 0 set gives a one-clock pulse on shutdown_req.
- R7: An aux1 write with bit 1 set gives a one-clock pulse on fd_tc. The byte is stored with bit 1 forced to 0.
- R8: A system-control write with bit 0 set loads the word with 0x00000002 and gives a one-clock pulse on sys_reset_req. A write with bit 0 clear has no effect.
- R9: Any write to the power-management location gives a one-clock pulse on cpu_halt_req. Reads of that location return zero.
- R10: The system reset rst_n clears the configuration, aux1, aux2 and modem-control bytes. The diagnostic byte, the system-control word and the LED word keep their values.
- R11: The power-on reset por_n clears every register, including the diagnostic byte, the system-control word and the LED word.
- R12: Byte registers store the low 8 bits of wr_data and the LED word stores the low 16 bits. Reads return the stored value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pwr_fail | input | 1 | Power-fail indication, synchronous to clk |
| pf_irq | output | 1 | Registered power-fail interrupt |
| fd_tc | output | 1 | Floppy terminal-count pulse |
| shutdown_req | output | 1 | Power-off request pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| cpu_halt_req | output | 1 | CPU halt request pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address and a main base of 0x71000000, so the five main offsets, the two auxiliary bases and the power-management base are all distinct full-width addresses. With this map the bench can show that a near-miss address in the main window reads zero and leaves the configuration byte untouched. With the same build it drives the interlocks in sequence: power fail seen with the enable off and then with it on, masking and unmasking the interrupt, clearing the status, and the two reset levels with their different survivors.

// File: rtl/auxio_pkg.sv
`timescale 1ns/1ps
package auxio_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // field positions that neighbouring logic depends on
  localparam int CFG_PFEN_BIT  = 3;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int AUX1_TC_BIT   = 1;
  localparam int SYS_CMD_BIT   = 0;
  localparam logic [DATA_W-1:0] SYS_RESET_STATUS = 32'h0000_0002;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_DIAG, SEL_MDM, SEL_LED,
    SEL_SYS, SEL_AUX1, SEL_AUX2, SEL_PM
  } sel_e;

  // aux2 contents after a software write
  function automatic logic [BYTE_W-1:0] aux2_after_write(
      input logic [BYTE_W-1:0] cur, input logic [BYTE_W-1:0] wd);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[AUX2_OFF_BIT] = wd[AUX2_OFF_BIT];
    v[AUX2_CLR_BIT] = wd[AUX2_CLR_BIT];
    v[AUX2_PF_BIT]  = cur[AUX2_PF_BIT];
    if (v[AUX2_CLR_BIT]) begin
      v[AUX2_PF_BIT]  = 1'b0;
      v[AUX2_CLR_BIT] = 1'b0;
    end
    return v;
  endfunction

  // aux1 byte as stored: the command bit never sticks
  function automatic logic [BYTE_W-1:0] aux1_stored(input logic [BYTE_W-1:0] wd);
    logic [BYTE_W-1:0] v;
    v = wd;
    v[AUX1_TC_BIT] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/auxio_addr_dec.sv
`timescale 1ns/1ps
module auxio_addr_dec
  import auxio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] MAIN_BASE = ADDR_W'(32'h7100_0000),
  parameter logic [ADDR_W-1:0] AUX1_BASE = ADDR_W'(32'h7190_0000),
  parameter logic [ADDR_W-1:0] AUX2_BASE = ADDR_W'(32'h7191_0000),
  parameter logic [ADDR_W-1:0] PM_BASE   = ADDR_W'(32'h6A00_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  localparam int NSLOT = 8;

  // slot i maps to enum value i+1
  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    case (i)
      0:       return MAIN_BASE + ADDR_W'(32'h0180_0000);
      1:       return MAIN_BASE + ADDR_W'(32'h01A0_0000);
      2:       return MAIN_BASE + ADDR_W'(32'h01B0_0000);
      3:       return MAIN_BASE + ADDR_W'(32'h0160_0000);
      4:       return MAIN_BASE + ADDR_W'(32'h01F0_0000);
      5:       return AUX1_BASE;
      6:       return AUX2_BASE;
      default: return PM_BASE;
    endcase
  endfunction

  logic [NSLOT-1:0] hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hit[g] = (addr == slot_addr(g));
  end

  always_comb begin
    sel = SEL_NONE;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) sel = sel_e'(4'(i + 1));
    end
  end

  // R1: the address map never resolves one address to two registers
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/auxio_pwr_ctl.sv
`timescale 1ns/1ps
module auxio_pwr_ctl
  import auxio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              aux2_wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              pwr_fail,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              irq,
  output logic              shutdown
);
  logic              pf_q;
  logic              pf_change;
  logic [BYTE_W-1:0] cfg_nx;
  logic [BYTE_W-1:0] aux2_w;
  logic [BYTE_W-1:0] aux2_nx;

  assign pf_change = pwr_fail ^ pf_q;
  assign cfg_nx    = cfg_wr  ? wbyte : cfg_q;
  assign aux2_w    = aux2_wr ? aux2_after_write(aux2_q, wbyte) : aux2_q;

  always_comb begin
    aux2_nx = aux2_w;
    if (pf_change) aux2_nx[AUX2_PF_BIT] = pwr_fail & cfg_q[CFG_PFEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q     <= 1'b0;
      cfg_q    <= '0;
      aux2_q   <= '0;
      irq      <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      pf_q     <= pwr_fail;
      cfg_q    <= cfg_nx;
      aux2_q   <= aux2_nx;
      irq      <= aux2_nx[AUX2_PF_BIT] & cfg_nx[CFG_PFEN_BIT];
      shutdown <= aux2_wr & aux2_w[AUX2_OFF_BIT];
    end
  end

  // R3: interrupt only with latched status and enable
  a_r3_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PFEN_BIT]));
  // R5: a clear write without a competing input change drops the status
  a_r5_clear_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_wr && wbyte[AUX2_CLR_BIT] && !pf_change) |=>
      (!aux2_q[AUX2_PF_BIT] && !aux2_q[AUX2_CLR_BIT]));
  // R6: shutdown only follows an aux2 write
  a_r6_shutdown_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> ($past(aux2_wr) && aux2_q[AUX2_OFF_BIT]));
endmodule

// File: rtl/auxio_cmd.sv
`timescale 1ns/1ps
module auxio_cmd
  import auxio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              aux1_wr,
  input  logic              sys_wr,
  input  logic              pm_wr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] aux1_q,
  output logic [DATA_W-1:0] sysctl_q,
  output logic              tc_pulse,
  output logic              sysrst_pulse,
  output logic              halt_pulse
);
  logic tc_fire;
  logic sys_fire;

  assign tc_fire  = aux1_wr & wbyte[AUX1_TC_BIT];
  assign sys_fire = sys_wr  & wbyte[SYS_CMD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux1_q       <= '0;
      tc_pulse     <= 1'b0;
      sysrst_pulse <= 1'b0;
      halt_pulse   <= 1'b0;
    end else begin
      if (aux1_wr) aux1_q <= aux1_stored(wbyte);
      tc_pulse     <= tc_fire;
      sysrst_pulse <= sys_fire;
      halt_pulse   <= pm_wr;
    end
  end

  // reset-status word survives system reset; only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        sysctl_q <= '0;
    else if (sys_fire) sysctl_q <= SYS_RESET_STATUS;
  end

  // R7: terminal-count pulse traces back to an aux1 write
  a_r7_tc_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(aux1_wr));
  // R7: the command bit is never held in the stored byte
  a_r7_tc_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    aux1_wr |=> !aux1_q[AUX1_TC_BIT]);
  // R8: reset request comes with the reset-status word loaded
  a_r8_status_with_request: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sysrst_pulse |-> (sysctl_q == SYS_RESET_STATUS));
  // R9: halt request traces back to a power-management write
  a_r9_halt_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> $past(pm_wr));
endmodule

// File: rtl/auxio_sysctl_regs.sv
`timescale 1ns/1ps
module auxio_sysctl_regs
  import auxio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] MAIN_BASE = ADDR_W'(32'h7100_0000),
  parameter logic [ADDR_W-1:0] AUX1_BASE = ADDR_W'(32'h7190_0000),
  parameter logic [ADDR_W-1:0] AUX2_BASE = ADDR_W'(32'h7191_0000),
  parameter logic [ADDR_W-1:0] PM_BASE   = ADDR_W'(32'h6A00_0000),
  parameter int LED_W = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              pwr_fail,
  output logic              pf_irq,
  output logic              fd_tc,
  output logic              shutdown_req,
  output logic              sys_reset_req,
  output logic              cpu_halt_req
);
  logic              sys_rst_n;
  sel_e              sel;
  logic [BYTE_W-1:0] wbyte;
  logic [BYTE_W-1:0] cfg_q, aux2_q, aux1_q, diag_q, mdm_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sysctl_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wr_hi;

  assign sys_rst_n    = rst_n & por_n;
  assign wbyte        = wr_data[BYTE_W-1:0];
  assign unused_wr_hi = ^wr_data[DATA_W-1:LED_W];

  auxio_addr_dec #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .AUX1_BASE(AUX1_BASE),
    .AUX2_BASE(AUX2_BASE), .PM_BASE(PM_BASE)
  ) dec_i (
    .clk(clk), .rst_n(sys_rst_n), .addr(bus_addr), .sel(sel)
  );

  auxio_pwr_ctl pwr_i (
    .clk(clk), .rst_n(sys_rst_n),
    .cfg_wr(bus_wr && sel == SEL_CFG), .aux2_wr(bus_wr && sel == SEL_AUX2),
    .wbyte(wbyte), .pwr_fail(pwr_fail),
    .cfg_q(cfg_q), .aux2_q(aux2_q), .irq(pf_irq), .shutdown(shutdown_req)
  );

  auxio_cmd cmd_i (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_n),
    .aux1_wr(bus_wr && sel == SEL_AUX1), .sys_wr(bus_wr && sel == SEL_SYS),
    .pm_wr(bus_wr && sel == SEL_PM), .wbyte(wbyte),
    .aux1_q(aux1_q), .sysctl_q(sysctl_q),
    .tc_pulse(fd_tc), .sysrst_pulse(sys_reset_req), .halt_pulse(cpu_halt_req)
  );

  // modem control follows system reset
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                   mdm_q <= '0;
    else if (bus_wr && sel == SEL_MDM) mdm_q <= wbyte;
  end

  // diagnostic byte and LED word only clear at power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      diag_q <= '0;
      led_q  <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_DIAG) diag_q <= wbyte;
      if (sel == SEL_LED)  led_q  <= wr_data[LED_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CFG:  rd_mux = DATA_W'(cfg_q);
      SEL_DIAG: rd_mux = DATA_W'(diag_q);
      SEL_MDM:  rd_mux = DATA_W'(mdm_q);
      SEL_LED:  rd_mux = DATA_W'(led_q);
      SEL_SYS:  rd_mux = sysctl_q;
      SEL_AUX1: rd_mux = DATA_W'(aux1_q);
      SEL_AUX2: rd_mux = DATA_W'(aux2_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rd_data <= '0;
    else            rd_data <= bus_rd ? rd_mux : '0;
  end

  // R2: data only in the cycle after a read strobe
  a_r2_data_after_read: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rd_data != '0) |-> $past(bus_rd));
  // R1: a write outside the map leaves the configuration byte alone
  a_r1_unmapped_write: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_wr && sel == SEL_NONE && !pwr_fail && !$past(pwr_fail)) |=> $stable(cfg_q));
endmodule

// File: tb/auxio_sysctl_regs_tb_top.sv
`timescale 1ns/1ps
module auxio_sysctl_regs_tb_top;
  localparam logic [31:0] MB    = 32'h7100_0000;
  localparam logic [31:0] A_CFG = MB + 32'h0180_0000;
  localparam logic [31:0] A_DIA = MB + 32'h01A0_0000;
  localparam logic [31:0] A_MDM = MB + 32'h01B0_0000;
  localparam logic [31:0] A_LED = MB + 32'h0160_0000;
  localparam logic [31:0] A_SYS = MB + 32'h01F0_0000;
  localparam logic [31:0] A_AX1 = 32'h7190_0000;
  localparam logic [31:0] A_AX2 = 32'h7191_0000;
  localparam logic [31:0] A_PM  = 32'h6A00_0000;
  localparam logic [31:0] A_BAD = MB + 32'h0170_0000;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic [31:0] bus_addr = '0, wr_data = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, pwr_fail = 1'b0;
  logic [31:0] rd_data;
  logic pf_irq, fd_tc, shutdown_req, sys_reset_req, cpu_halt_req;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  auxio_sysctl_regs dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .wr_data(wr_data), .rd_data(rd_data),
    .pwr_fail(pwr_fail), .pf_irq(pf_irq), .fd_tc(fd_tc),
    .shutdown_req(shutdown_req), .sys_reset_req(sys_reset_req),
    .cpu_halt_req(cpu_halt_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: actual unexpected read data %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk);
    pwr_fail = v;
    @(negedge clk);
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 irq after power-on", 32'(pf_irq), 0);
    rd(A_CFG, 0, "R11 cfg after power-on");
    rd(A_AX2, 0, "R11 aux2 after power-on");
    rd(A_DIA, 0, "R11 diag after power-on");
    rd(A_SYS, 0, "R11 sysctl after power-on");
    rd(A_LED, 0, "R11 led after power-on");
    // R12 widths
    wr(A_CFG, 32'h0000_00A5); rd(A_CFG, 32'hA5, "R12 cfg byte");
    wr(A_CFG, 32'h1234_5608); rd(A_CFG, 32'h08, "R12 cfg low byte only");
    @(negedge clk);
    check("R2 idle rd_data zero", rd_data, 0);
    wr(A_DIA, 32'hFFFF_FF3C); rd(A_DIA, 32'h3C, "R12 diag");
    wr(A_MDM, 32'h0000_005A); rd(A_MDM, 32'h5A, "R12 mdm");
    wr(A_LED, 32'hFFFF_BEEF); rd(A_LED, 32'hBEEF, "R12 led 16 bit");
    // R1 unmapped
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, 0, "R1 unmapped reads zero");
    rd(A_CFG, 32'h08, "R1 unmapped write ignored");
    // R4/R3 power fail with enable on
    set_pf(1'b1);
    check("R3 irq on power fail", 32'(pf_irq), 1);
    rd(A_AX2, 32'h20, "R4 status latched");
    wr(A_CFG, 0);
    check("R3 irq masked by enable", 32'(pf_irq), 0);
    rd(A_AX2, 32'h20, "R4 status kept while masked");
    wr(A_CFG, 32'h08);
    check("R3 irq unmasked", 32'(pf_irq), 1);
    // R5 write keeps status
    wr(A_AX2, 32'hFC);
    check("R6 no shutdown", 32'(shutdown_req), 0);
    rd(A_AX2, 32'h20, "R5 mask and carry");
    check("R3 irq after carry", 32'(pf_irq), 1);
    wr(A_AX2, 32'h02);
    check("R3 irq after clear", 32'(pf_irq), 0);
    rd(A_AX2, 0, "R5 clear drops status");
    // R4 input seen with enable off
    set_pf(1'b0);
    wr(A_CFG, 0);
    set_pf(1'b1);
    rd(A_AX2, 0, "R4 no latch while disabled");
    wr(A_CFG, 32'h08);
    check("R3 enable without status", 32'(pf_irq), 0);
    set_pf(1'b0);
    set_pf(1'b1);
    check("R3 irq on new edge", 32'(pf_irq), 1);
    // R6 power off with clear
    wr(A_AX2, 32'h03);
    check("R6 shutdown pulse", 32'(shutdown_req), 1);
    check("R3 irq after clear+off", 32'(pf_irq), 0);
    @(negedge clk);
    check("R6 shutdown one cycle", 32'(shutdown_req), 0);
    rd(A_AX2, 32'h01, "R5 only power-off bit left");
    // R7
    wr(A_AX1, 32'hFF);
    check("R7 tc pulse", 32'(fd_tc), 1);
    @(negedge clk);
    check("R7 tc one cycle", 32'(fd_tc), 0);
    rd(A_AX1, 32'hFD, "R7 tc bit not stored");
    wr(A_AX1, 32'h40);
    check("R7 no tc", 32'(fd_tc), 0);
    rd(A_AX1, 32'h40, "R7 plain store");
    // R8
    wr(A_SYS, 0);
    check("R8 no request", 32'(sys_reset_req), 0);
    rd(A_SYS, 0, "R8 bit0 clear no effect");
    wr(A_SYS, 32'hFFFF_FFFF);
    check("R8 reset request", 32'(sys_reset_req), 1);
    @(negedge clk);
    check("R8 request one cycle", 32'(sys_reset_req), 0);
    rd(A_SYS, 32'h2, "R8 reset status");
    // R9
    wr(A_PM, 32'h55);
    check("R9 halt pulse", 32'(cpu_halt_req), 1);
    @(negedge clk);
    check("R9 halt one cycle", 32'(cpu_halt_req), 0);
    rd(A_PM, 0, "R9 pm reads zero");
    // R10 system reset
    pulse_rst(1'b0);
    rd(A_CFG, 0, "R10 cfg cleared");
    rd(A_AX1, 0, "R10 aux1 cleared");
    rd(A_AX2, 0, "R10 aux2 cleared");
    rd(A_MDM, 0, "R10 mdm cleared");
    rd(A_DIA, 32'h3C, "R10 diag kept");
    rd(A_SYS, 32'h2, "R10 sysctl kept");
    rd(A_LED, 32'hBEEF, "R10 led kept");
    // R11 power-on
    pulse_rst(1'b1);
    rd(A_DIA, 0, "R11 diag cleared");
    rd(A_SYS, 0, "R11 sysctl cleared");
    rd(A_LED, 0, "R11 led cleared");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule